// File: doc/BRIEF.md
# External Interrupt Conditioning Controller

This block takes a bank of asynchronous external interrupt pins and turns each one into a clean, active-high, level-style request for an on-chip interrupt controller. Software chooses per line whether the pin is watched for a level or for an edge, and which polarity counts as active. Edge events are held in a pending latch until software acknowledges them. Level events are pending for exactly as long as the pin sits at its active level. Every line can be masked on its own. The unmasked pending lines are combined into one request output.

Software reaches the block through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the address. The port has set-to-unmask and set-to-mask registers, an acknowledge register, three per-line configuration registers and a masked pending status register. The number of implemented lines is a parameter. Configuration bits above that count cannot be written and always read as zero, so software can find the line count by writing all ones to the trigger-select register and reading it back.

Top module: `ext_irq_conditioner`

## Requirements
- R1: Register 3 (trigger select) holds one bit per line, with bit i for line i. A 1 makes the line level-sensitive and a 0 makes it edge-sensitive. Putting a line into level mode discards any edge it had latched.
- R2: Register 4 (edge polarity) chooses, for an edge-mode line, which transition sets its pending latch: 1 for low-to-high, 0 for high-to-low. Transitions in the other direction, and changes of the polarity bit itself, set nothing.
- R3: Register 5 (level polarity) chooses the active level of a level-mode line: 1 for high, 0 for low. A level-mode line is pending exactly while its synchronized pin is at that level, and an acknowledge write leaves it unchanged.
- R4: Writing register 0 unmasks every line whose data bit is 1. Lines whose data bit is 0 keep their mask state. Reads of register 0 or register 1 return the current unmask vector, with 1 meaning enabled.
- R5: Writing register 1 masks every line whose data bit is 1. Lines whose data bit is 0 keep their mask state.
- R6: Writing register 2 with bit i set clears line i's latched edge. If a new edge on that line is detected in the same cycle as the acknowledge write, the latch stays set.
- R7: Register 6 reads pending AND unmasked, per line. The request output is the OR of those bits. A masked line keeps its latched edge, and the edge shows up once the line is unmasked.
- R8: Register bits at or above the implemented line count ignore writes and read as zero. Writing all ones to register 3 reads back as 2^N-1.
- R9: After reset, all lines are masked, in edge mode, set for high-to-low edges and active-low, with nothing pending and the request output low.
- R10: Each pin passes through a two-flop synchronizer. A level-mode pin change becomes visible in register 6 after two clock edges and not after one. An edge-mode event becomes visible after three edges and not after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | NUM_LINES | Raw asynchronous external interrupt pins |
| reg_wr_i | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Combinational read data for reg_addr_i |
| irq_req_o | output | 1 | Combined active-high request: OR of pending and unmasked lines |

## Verification
The bench builds the block with six lines on a sixteen-bit data bus, so the ten unimplemented upper bits are reachable. This lets the bench check that those bits ignore writes and read as zero, and that an all-ones trigger-select write returns 0x003F. The synchronizer is kept at its default depth of two, so the bench can count the cycles each line needs before a level or an edge appears. Random register writes and pin changes cover mixed modes and polarities across all six lines. Directed cases cover the reset state, an acknowledge that lands in the same cycle as a new edge, and an edge latched while its line is masked.

// File: rtl/eic_pkg.sv
package eic_pkg;
   localparam int REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_UNMASK = 3'd0,
      REG_MASK   = 3'd1,
      REG_ACK    = 3'd2,
      REG_TRIG   = 3'd3,
      REG_RISE   = 3'd4,
      REG_HIGH   = 3'd5,
      REG_STATUS = 3'd6,
      REG_SPARE  = 3'd7
   } eic_reg_e;

   typedef struct packed {
      logic level_mode;
      logic rise_sel;
      logic high_sel;
   } eic_line_cfg_t;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
   parameter int LINES  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] async_i,
   output logic [LINES-1:0] sync_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("eic_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][LINES-1:0] stg_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign sync_o = stg_q[LAST];
endmodule

// File: rtl/eic_detect.sv
module eic_detect #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] sync_i,
   input  logic [LINES-1:0] trig_level_i,
   input  logic [LINES-1:0] rise_sel_i,
   input  logic [LINES-1:0] high_sel_i,
   input  logic [LINES-1:0] ack_i,
   output logic [LINES-1:0] pend_o
);
   import eic_pkg::*;

   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] latch_q;
   logic [LINES-1:0] edge_evt;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      eic_line_cfg_t cfg;
      logic          went_up;
      logic          went_down;
      logic          at_active;

      assign cfg.level_mode = trig_level_i[i];
      assign cfg.rise_sel   = rise_sel_i[i];
      assign cfg.high_sel   = high_sel_i[i];

      assign went_up   =  sync_i[i] & ~prev_q[i];
      assign went_down = ~sync_i[i] &  prev_q[i];
      assign at_active = ~(sync_i[i] ^ cfg.high_sel);
      assign edge_evt[i] = ~cfg.level_mode &
                           (cfg.rise_sel ? went_up : went_down);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[i]  <= 1'b0;
            latch_q[i] <= 1'b0;
         end else begin
            prev_q[i] <= sync_i[i];
            if (cfg.level_mode)   latch_q[i] <= 1'b0;
            else if (edge_evt[i]) latch_q[i] <= 1'b1;
            else if (ack_i[i])    latch_q[i] <= 1'b0;
         end
      end

      assign pend_o[i] = cfg.level_mode ? at_active : latch_q[i];

      AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_evt[i]) |=> latch_q[i]) else $error("edge not latched"); // R2
      AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_evt[i] && ack_i[i]) |=> latch_q[i]) else $error("ack beat edge"); // R6
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (!edge_evt[i] && ack_i[i] && !trig_level_i[i]) |=> !latch_q[i]) else $error("ack ignored"); // R6
      AST_LEVEL_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_level_i[i]) |=> !latch_q[i]) else $error("latch kept in level mode"); // R1
   end
endmodule

// File: rtl/eic_regs.sv
module eic_regs #(
   parameter int LINES  = 8,
   parameter int DATA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_i,
   input  logic [eic_pkg::REG_ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0]           wdata_i,
   output logic [DATA_W-1:0]           rdata_o,
   input  logic [LINES-1:0]            pend_i,
   output logic [LINES-1:0]            unmask_o,
   output logic [LINES-1:0]            trig_level_o,
   output logic [LINES-1:0]            rise_sel_o,
   output logic [LINES-1:0]            high_sel_o,
   output logic [LINES-1:0]            ack_o
);
   import eic_pkg::*;

   localparam int PAD_W = DATA_W - LINES;

   eic_reg_e         sel;
   logic [LINES-1:0] wbits;
   logic [LINES-1:0] en_q, trig_q, rise_q, high_q;
   logic [LINES-1:0] status;
   logic [LINES-1:0] rd_narrow;

   assign sel   = eic_reg_e'(addr_i);
   assign wbits = wdata_i[LINES-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         trig_q <= '0;
         rise_q <= '0;
         high_q <= '0;
      end else if (wr_i) begin
         case (sel)
            REG_UNMASK: en_q   <= en_q | wbits;
            REG_MASK:   en_q   <= en_q & ~wbits;
            REG_TRIG:   trig_q <= wbits;
            REG_RISE:   rise_q <= wbits;
            REG_HIGH:   high_q <= wbits;
            default:    ;
         endcase
      end
   end

   assign ack_o  = (wr_i && sel == REG_ACK) ? wbits : '0;
   assign status = pend_i & en_q;

   always_comb begin
      case (sel)
         REG_UNMASK, REG_MASK: rd_narrow = en_q;
         REG_TRIG:             rd_narrow = trig_q;
         REG_RISE:             rd_narrow = rise_q;
         REG_HIGH:             rd_narrow = high_q;
         REG_STATUS:           rd_narrow = status;
         default:              rd_narrow = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign rdata_o = {{PAD_W{1'b0}}, rd_narrow};
   end else begin : g_full
      assign rdata_o = rd_narrow;
   end

   assign unmask_o     = en_q;
   assign trig_level_o = trig_q;
   assign rise_sel_o   = rise_q;
   assign high_sel_o   = high_q;

   AST_UNMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel == REG_UNMASK) |=> ((en_q & $past(wbits)) == $past(wbits))) else $error("unmask lost"); // R4
   AST_UNMASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel == REG_UNMASK) |=> ((en_q & $past(en_q)) == $past(en_q))) else $error("unmask dropped a line"); // R4
   AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel == REG_MASK) |=> ((en_q & $past(wbits)) == '0)) else $error("mask lost"); // R5
   AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel == REG_MASK) |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits)))) else $error("mask hit other line"); // R5
endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner #(
   parameter int NUM_LINES   = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_pin_i,
   input  logic                 reg_wr_i,
   input  logic [2:0]           reg_addr_i,
   input  logic [DATA_W-1:0]    reg_wdata_i,
   output logic [DATA_W-1:0]    reg_rdata_o,
   output logic                 irq_req_o
);
   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("ext_irq_conditioner: NUM_LINES must lie in 1..DATA_W");
   end
   if (eic_pkg::REG_ADDR_W != 3) begin : g_bad_addr
      $error("ext_irq_conditioner: register address width mismatch");
   end

   logic [NUM_LINES-1:0] pin_sync;
   logic [NUM_LINES-1:0] pend;
   logic [NUM_LINES-1:0] unmask;
   logic [NUM_LINES-1:0] trig_level;
   logic [NUM_LINES-1:0] rise_sel;
   logic [NUM_LINES-1:0] high_sel;
   logic [NUM_LINES-1:0] ack;

   eic_sync #(.LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(irq_pin_i),
      .sync_o (pin_sync)
   );

   eic_detect #(.LINES(NUM_LINES)) u_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_i      (pin_sync),
      .trig_level_i(trig_level),
      .rise_sel_i  (rise_sel),
      .high_sel_i  (high_sel),
      .ack_i       (ack),
      .pend_o      (pend)
   );

   eic_regs #(.LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (reg_wr_i),
      .addr_i      (reg_addr_i),
      .wdata_i     (reg_wdata_i),
      .rdata_o     (reg_rdata_o),
      .pend_i      (pend),
      .unmask_o    (unmask),
      .trig_level_o(trig_level),
      .rise_sel_o  (rise_sel),
      .high_sel_o  (high_sel),
      .ack_o       (ack)
   );

   assign irq_req_o = |(pend & unmask);

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (unmask == '0) |-> !irq_req_o) else $error("request while all masked"); // R7
   AST_PEND_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_level != '0 && $stable(trig_level) && $stable(high_sel))
      |-> ((pend & trig_level) == (~(pin_sync ^ high_sel) & trig_level))) else $error("level pend mismatch"); // R3
endmodule

// File: tb/sim_ext_irq_conditioner.sv
module sim_ext_irq_conditioner;
   localparam int N  = 6;
   localparam int DW = 16;
   localparam logic [N-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins = '0;
   logic          wr = 1'b0;
   logic [2:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [N-1:0] m_en = '0, m_mode = '0, m_rise = '0, m_high = '0, m_latch = '0, m_pins = '0;

   always #4 clk = ~clk;

   ext_irq_conditioner #(.NUM_LINES(N), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_pin_i(pins), .reg_wr_i(wr),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_req_o(irq)
   );

   function automatic logic [N-1:0] exp_status();
      return ((m_mode & ~(m_pins ^ m_high)) | (m_latch & ~m_mode)) & m_en;
   endfunction

   task automatic tick(int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic rd(logic [2:0] a, output logic [DW-1:0] v);
      addr = a; #1; v = rdata;
   endtask

   task automatic wreg(logic [2:0] a, logic [DW-1:0] d);
      logic [N-1:0] b;
      b = d[N-1:0];
      wr = 1'b1; addr = a; wdata = d;
      tick(1);
      wr = 1'b0;
      case (a)
         3'd0: m_en = m_en | b;
         3'd1: m_en = m_en & ~b;
         3'd2: m_latch = m_latch & ~b;
         3'd3: begin m_mode = b; m_latch = m_latch & ~b; end
         3'd4: m_rise = b;
         3'd5: m_high = b;
         default: ;
      endcase
   endtask

   task automatic set_pins(logic [N-1:0] nv);
      logic [N-1:0] up, dn;
      up = nv & ~m_pins;
      dn = ~nv & m_pins;
      m_latch = m_latch | (~m_mode & ((m_rise & up) | (~m_rise & dn)));
      m_pins = nv;
      pins = nv;
      tick(4);
   endtask

   task automatic check_all(string req);
      logic [DW-1:0] v;
      tick(1);
      rd(3'd0, v); check({req, " R4 unmask"}, v, {{(DW-N){1'b0}}, m_en});
      rd(3'd3, v); check({req, " R1 trig"},   v, {{(DW-N){1'b0}}, m_mode});
      rd(3'd4, v); check({req, " R2 rise"},   v, {{(DW-N){1'b0}}, m_rise});
      rd(3'd5, v); check({req, " R3 high"},   v, {{(DW-N){1'b0}}, m_high});
      rd(3'd6, v); check({req, " R7 status"}, v, {{(DW-N){1'b0}}, exp_status()});
      check({req, " R7 irq"}, {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, |exp_status()});
   endtask

   initial begin
      #1600000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      void'($urandom(32'h5EED_0017));
      @(negedge clk); tick(2);
      // R9 reset state
      rd(3'd0, v); check("R9 unmask", v, '0);
      rd(3'd3, v); check("R9 trig", v, '0);
      rd(3'd6, v); check("R9 status", v, '0);
      check("R9 irq", {{(DW-1){1'b0}}, irq}, '0);
      rst_n = 1'b1;
      tick(2);
      check_all("R9 after release");

      // R8 unimplemented bits and line discovery
      wreg(3'd3, '1);
      rd(3'd3, v); check("R8 line count", v, 16'h003F);
      wreg(3'd4, 16'hFFC0);
      rd(3'd4, v); check("R8 spare bits", v, '0);
      wreg(3'd3, '0);
      wreg(3'd4, '0);

      // R10 level timing on line 0 (active high)
      wreg(3'd0, 16'h0003);
      wreg(3'd3, 16'h0001);
      wreg(3'd5, 16'h0001);
      wreg(3'd4, 16'h0002);
      tick(3);
      pins = 6'b000001; m_pins = 6'b000001;
      tick(1); rd(3'd6, v); check("R10 level after one edge", v, '0);
      tick(1); rd(3'd6, v); check("R10 level after two edges", v, 16'h0001);
      // R10 edge timing on line 1 (rising)
      pins = 6'b000011; m_pins = 6'b000011;
      tick(2); rd(3'd6, v); check("R10 edge after two edges", v, 16'h0001);
      tick(1); rd(3'd6, v); check("R10 edge after three edges", v, 16'h0003);
      m_latch[1] = 1'b1;
      // R3 ack does not affect level line
      wreg(3'd2, 16'h0001);
      tick(1); rd(3'd6, v); check("R3 ack on level line", v, 16'h0003);
      // R6 plain ack clears edge
      wreg(3'd2, 16'h0002);
      tick(1); rd(3'd6, v); check("R6 ack clears", v, 16'h0001);
      // R6 edge in same cycle as ack wins
      set_pins(6'b000001);
      pins = 6'b000011; m_pins = 6'b000011;
      tick(2);
      wreg(3'd2, 16'h0002);
      m_latch[1] = 1'b1;
      tick(1); rd(3'd6, v); check("R6 edge beats ack", v, 16'h0003);
      // R7 masked line keeps its latch
      wreg(3'd1, 16'h0002);
      rd(3'd6, v); check("R7 masked hidden", v, 16'h0001);
      wreg(3'd0, 16'h0002);
      rd(3'd6, v); check("R7 unmask reveals", v, 16'h0003);
      // R2 wrong direction edge does not latch
      wreg(3'd2, 16'h0002);
      set_pins(6'b000001);
      rd(3'd6, v); check("R2 falling ignored in rise mode", v, 16'h0001);
      // R1 level mode discards a latched edge
      set_pins(6'b000011);
      wreg(3'd3, 16'h0003);
      wreg(3'd5, 16'h0000);
      check_all("R1 switch to level");
      // R4 R5 zero bits have no effect
      wreg(3'd0, 16'h0000);
      wreg(3'd1, 16'h0000);
      check_all("R4 R5 zero writes");

      for (int it = 0; it < 400; it++) begin
         if ($urandom_range(0, 2) == 0) set_pins(N'($urandom));
         else wreg(3'($urandom_range(0, 5)), DW'($urandom));
         check_all("random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule